// File: doc/BRIEF.md
# Supply Power-On and Undervoltage Lockout Sequencer

This block decides how a sensor's output driver behaves while its supply ramps, sags and collapses. It reads four supply-monitor comparator flags and a stored-configuration fault flag. From these it produces a two-bit driver mode: high impedance, forced to ground, or normal drive. The comparator flags are asynchronous to the block clock. Each is passed through a two-flop synchronizer before any decision uses it.

Three timers, counted in clock cycles, pace the transitions:

- **Release timer.** It starts once the supply is above the power-on threshold.
- **Disable delay.** It runs while the supply sits above the lockout-release level.
- **Engage timer.** It qualifies a sag below the lockout-engage level before the output is grounded.

If the qualifying condition of any timer lapses, that timer returns to zero. A later qualifying event therefore starts a full new interval. A collapse below the power-on-reset low level, or an uncorrectable configuration fault, sends the output straight to high impedance. A one-cycle ready pulse marks each entry into normal drive.

Timer lengths are given in microseconds and converted to cycles through a clock-frequency parameter. The defaults are 64 µs for release, 64 µs for engage and 14 µs for disable.

Top module: `supply_seq`

## Requirements
- R1: After reset, and while no supply flag is asserted, mode is 00 (high impedance) and ready is 0.
- R2: After the power-on-high flag rises with the release-level flag already high, mode stays 00 until the release timer (REL_US) has run, then becomes 10 (normal drive).
- R3: If the release timer expires while the release-level flag is low, mode stays 00. When the flag rises, mode becomes 10 only after the disable delay (DIS_US).
- R4: In normal drive, the engage flag held high for the engage time (ENG_US) changes mode to 01 (ground).
- R5: In normal drive, an engage-flag pulse shorter than the engage time leaves mode at 10. The engage timer restarts from zero on each new pulse.
- R6: In ground mode, the release-level flag held high for the disable delay returns mode to 10. If the flag drops during the delay, the delay restarts from zero.
- R7: The power-on-reset low flag sends mode to 00 from normal drive (also while the engage timer runs) and from ground mode. A later recovery then needs the full release sequence.
- R8: A configuration fault forces mode to 00 from the next clock on. Mode stays 00 regardless of the supply flags until reset.
- R9: ready is high for exactly one cycle on each entry into normal drive, and only in a cycle where mode is 10.
- R10: Mode takes only the codes 00, 01 and 10; 11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_hi_raw | input | 1 | Supply above power-on-reset high level (asynchronous) |
| por_lo_raw | input | 1 | Supply below power-on-reset low level (asynchronous) |
| uv_rel_raw | input | 1 | Supply above lockout-release level (asynchronous) |
| uv_eng_raw | input | 1 | Supply below lockout-engage level (asynchronous) |
| cfg_fault | input | 1 | Uncorrectable stored-configuration error (synchronous) |
| mode | output | 2 | Driver mode: 00 high impedance, 01 ground, 10 normal |
| ready | output | 1 | One-cycle pulse on each entry into normal drive |

## Verification
Power-up is driven two ways:

- The release-level flag is already high when the power-on flag rises. This exercises the release timer.
- The release-level flag rises only after the release timer has expired. This separates the disable delay from the release interval.

Sags into the engage band are applied both as one long interval and as two short pulses whose sum exceeds the engage time. The second pattern is passed only by a timer that clears between pulses. The exit from ground mode is tried with an interrupted release-level pulse followed by a clean one, for the same reason. Collapses below the power-on-reset low level are driven mid-engage and from ground mode. A fault is then injected, and the output must ignore any supply flags that follow it.

// File: rtl/supply_seq.sv
module supply_seq #(
  parameter int CLK_HZ = 200_000_000,
  parameter int REL_US = 64,
  parameter int ENG_US = 64,
  parameter int DIS_US = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_hi_raw,
  input  logic       por_lo_raw,
  input  logic       uv_rel_raw,
  input  logic       uv_eng_raw,
  input  logic       cfg_fault,
  output logic [1:0] mode,
  output logic       ready
);
  localparam int CYC_US = CLK_HZ / 1_000_000;
  localparam int REL_N  = CYC_US * REL_US;
  localparam int ENG_N  = CYC_US * ENG_US;
  localparam int DIS_N  = CYC_US * DIS_US;
  localparam int MAX_A  = (REL_N > ENG_N) ? REL_N : ENG_N;
  localparam int MAX_N  = (MAX_A > DIS_N) ? MAX_A : DIS_N;
  localparam int CW     = $clog2(MAX_N + 1);

  typedef enum logic [2:0] {S_OFF, S_ARM, S_RUN, S_LOCK, S_FAULT} st_t;

  st_t           state, nxt;
  logic [3:0]    sync1, sync2;
  logic          por_hi_s, por_lo_s, uv_rel_s, uv_eng_s;
  logic [CW-1:0] rel_cnt, eng_cnt, dis_cnt;
  logic          rel_done, eng_done, dis_done;
  logic          in_fault;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {por_hi_raw, por_lo_raw, uv_rel_raw, uv_eng_raw};
      sync2 <= sync1;
    end

  assign {por_hi_s, por_lo_s, uv_rel_s, uv_eng_s} = sync2;

  assign rel_done = (rel_cnt == CW'(REL_N));
  assign eng_done = (eng_cnt == CW'(ENG_N));
  assign dis_done = (dis_cnt == CW'(DIS_N));
  assign in_fault = (state == S_FAULT);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c, input int lim);
    return (c == CW'(lim)) ? c : c + 1'b1;
  endfunction

  always_comb begin
    nxt = state;
    unique case (state)
      S_OFF:   if (por_hi_s) nxt = S_ARM;
      S_ARM:   if (rel_done && dis_done) nxt = S_RUN;
      S_RUN:   if (eng_done) nxt = S_LOCK;
      S_LOCK:  if (dis_done) nxt = S_RUN;
      S_FAULT: nxt = S_FAULT;
      default: nxt = S_OFF;
    endcase
    if (por_lo_s && state != S_FAULT) nxt = S_OFF;
    if (cfg_fault) nxt = S_FAULT;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_OFF;
      rel_cnt <= '0;
      eng_cnt <= '0;
      dis_cnt <= '0;
      ready   <= 1'b0;
    end else begin
      state <= nxt;
      ready <= (nxt == S_RUN) && (state != S_RUN);
      if (nxt != state) begin
        rel_cnt <= '0;
        eng_cnt <= '0;
        dis_cnt <= '0;
      end else begin
        unique case (state)
          S_ARM: begin
            rel_cnt <= sat_inc(rel_cnt, REL_N);
            dis_cnt <= uv_rel_s ? sat_inc(dis_cnt, DIS_N) : '0;
          end
          S_RUN:  eng_cnt <= uv_eng_s ? sat_inc(eng_cnt, ENG_N) : '0;
          S_LOCK: dis_cnt <= uv_rel_s ? sat_inc(dis_cnt, DIS_N) : '0;
          default: ;
        endcase
      end
    end

  always_comb
    unique case (state)
      S_RUN:   mode = 2'b10;
      S_LOCK:  mode = 2'b01;
      default: mode = 2'b00;
    endcase
endmodule

// File: rtl/supply_seq_chk.sv
module supply_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       ready,
  input logic       por_lo_s,
  input logic       cfg_fault,
  input logic       in_fault
);
  a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  a_r9_ready_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mode == 2'b10 && $past(mode) != 2'b10));

  a_r4_ground_from_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> ($past(mode) == 2'b10 || $past(mode) == 2'b01));

  a_r7_collapse_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    por_lo_s |=> (mode == 2'b00));

  a_r8_fault_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fault |=> (mode == 2'b00 && !ready));

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    in_fault |=> in_fault);
endmodule

bind supply_seq supply_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ready(ready),
  .por_lo_s(por_lo_s), .cfg_fault(cfg_fault), .in_fault(in_fault)
);

// File: tb/supply_seq_bench.sv
module supply_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_hi_raw = 1'b0, por_lo_raw = 1'b0, uv_rel_raw = 1'b0, uv_eng_raw = 1'b0;
  logic cfg_fault = 1'b0;
  logic [1:0] mode;
  logic ready;
  int total = 0;
  int bad = 0;
  int ready_seen = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  supply_seq #(.CLK_HZ(1_000_000)) u_supply_seq (
    .clk(clk), .rst_n(rst_n), .por_hi_raw(por_hi_raw), .por_lo_raw(por_lo_raw),
    .uv_rel_raw(uv_rel_raw), .uv_eng_raw(uv_eng_raw), .cfg_fault(cfg_fault),
    .mode(mode), .ready(ready)
  );

  always @(negedge clk) if (rst_n && ready) ready_seen++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {por_hi_raw, por_lo_raw, uv_rel_raw, uv_eng_raw, cfg_fault} = '0;
    step(4);
    rst_n = 1'b1;
    step(1);
    ready_seen = 0;
  endtask

  task automatic power_up(input string tag);
    por_hi_raw = 1'b1;
    uv_rel_raw = 1'b1;
    step(60);
    chk(mode, 0, {tag, " before release"});
    step(12);
    chk(mode, 2, {tag, " after release"});
  endtask

  task automatic t_reset();
    do_reset();
    chk(mode, 0, "R1 reset mode");
    chk(ready, 0, "R1 reset ready");
    step(100);
    chk(mode, 0, "R1 R10 idle hiz");
  endtask

  task automatic t_release();
    do_reset();
    power_up("R2");
    chk(ready_seen, 1, "R9 one ready pulse");
  endtask

  task automatic t_late_release();
    do_reset();
    por_hi_raw = 1'b1;
    step(100);
    chk(mode, 0, "R3 waits for release level");
    uv_rel_raw = 1'b1;
    step(10);
    chk(mode, 0, "R3 disable delay running");
    step(12);
    chk(mode, 2, "R3 normal after delay");
  endtask

  task automatic t_engage();
    do_reset();
    power_up("R4 setup");
    uv_eng_raw = 1'b1;
    uv_rel_raw = 1'b0;
    step(60);
    chk(mode, 2, "R4 engage pending");
    step(12);
    chk(mode, 1, "R4 grounded");
  endtask

  task automatic t_cancel();
    do_reset();
    power_up("R5 setup");
    uv_eng_raw = 1'b1;
    uv_rel_raw = 1'b0;
    step(40);
    uv_eng_raw = 1'b0;
    uv_rel_raw = 1'b1;
    step(5);
    chk(mode, 2, "R5 first sag abandoned");
    uv_eng_raw = 1'b1;
    uv_rel_raw = 1'b0;
    step(40);
    chk(mode, 2, "R5 timer restarted");
    uv_eng_raw = 1'b0;
    uv_rel_raw = 1'b1;
    step(10);
    chk(mode, 2, "R5 still normal");
  endtask

  task automatic t_lock_exit();
    do_reset();
    power_up("R6 setup");
    uv_eng_raw = 1'b1;
    uv_rel_raw = 1'b0;
    step(72);
    chk(mode, 1, "R6 locked");
    uv_eng_raw = 1'b0;
    uv_rel_raw = 1'b1;
    step(8);
    uv_rel_raw = 1'b0;
    step(5);
    chk(mode, 1, "R6 interrupted delay");
    uv_rel_raw = 1'b1;
    step(10);
    chk(mode, 1, "R6 delay restarted");
    step(12);
    chk(mode, 2, "R6 back to normal");
    chk(ready_seen, 2, "R9 ready on lock exit");
  endtask

  task automatic t_por_drop();
    do_reset();
    power_up("R7 setup");
    uv_eng_raw = 1'b1;
    uv_rel_raw = 1'b0;
    step(30);
    por_lo_raw = 1'b1;
    por_hi_raw = 1'b0;
    step(4);
    chk(mode, 0, "R7 collapse during engage");
    step(80);
    chk(mode, 0, "R7 no ground after collapse");
    por_lo_raw = 1'b0;
    uv_eng_raw = 1'b0;
    power_up("R7 full release again");
    uv_eng_raw = 1'b1;
    uv_rel_raw = 1'b0;
    step(72);
    chk(mode, 1, "R7 locked before collapse");
    por_lo_raw = 1'b1;
    por_hi_raw = 1'b0;
    step(4);
    chk(mode, 0, "R7 collapse from ground");
  endtask

  task automatic t_fault();
    do_reset();
    power_up("R8 setup");
    cfg_fault = 1'b1;
    step(1);
    cfg_fault = 1'b0;
    chk(mode, 0, "R8 fault hiz");
    step(100);
    chk(mode, 0, "R8 fault sticky");
    por_lo_raw = 1'b1;
    step(10);
    por_lo_raw = 1'b0;
    step(100);
    chk(mode, 0, "R8 flags ignored");
    chk(ready_seen, 1, "R8 no new ready");
    do_reset();
    power_up("R8 recovery after reset");
  endtask

  initial begin
    t_reset();
    t_release();
    t_late_release();
    t_engage();
    t_cancel();
    t_lock_exit();
    t_por_drop();
    t_fault();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule